// File: doc/BRIEF.md
# Reset Qualifier and Power-Mode Controller

This block sits between the oscillator and the processor core. It filters the external reset pin so that only a level held for two whole machine cycles (24 oscillator periods) becomes a system reset. It also holds the two-bit power-control register through which software chooses between normal running, idle and power-down. The oscillator is seen as a one-cycle strobe `osc_tick` per oscillator period on a free-running reference clock `clk`. A divide-by-two stage turns those strobes into the internal clock enables, so the duty cycle of the incoming oscillator does not matter.

The controller has four named states. `S_RUN` is normal operation. `S_IDLE` stops the CPU clock enable but keeps the peripheral clock enable running. `S_PDOWN` drops the oscillator enable, which stops every clock. `S_RESET` holds the system reset asserted. The transitions are as follows. From `S_RUN`, a register write with the power-down bit set moves to `S_PDOWN`. From `S_RUN`, a write with only the idle bit set moves to `S_IDLE`. From `S_IDLE`, an enabled interrupt returns to `S_RUN`. From `S_RESET`, release of the reset pin returns to `S_RUN`. From any state, a qualified reset moves to `S_RESET`. While the oscillator is stopped in `S_PDOWN`, qualification counts `clk` cycles instead, so the reset pin can still end power-down.

Top module: `pmc_top`

## Requirements
- R1: After `arst_n` is released the block is in `S_RUN`: `pcon_q` = 00, `osc_en` = 1 and `sys_rst` = 0.
- R2: Outside power-down, `sys_rst` rises only at the clock edge that samples the 24th consecutive `osc_tick` with `rst_in` high. A shorter high pulse is ignored. The count restarts whenever `rst_in` is sampled low. `clk` cycles without `osc_tick` do not count.
- R3: In `S_PDOWN`, qualification counts every `clk` cycle, so 24 consecutive high samples of `rst_in` raise `sys_rst` with no `osc_tick` at all.
- R4: In `S_RUN`, a write (`pcon_we` = 1) with bit 0 = 1 and bit 1 = 0 enters `S_IDLE`. In `S_IDLE`, `cpu_clk_en` stays 0 and `per_clk_en` keeps pulsing.
- R5: In `S_IDLE`, `irq` = 1 returns the block to `S_RUN` and clears bit 0. In `S_RUN` or `S_PDOWN`, `irq` has no effect.
- R6: A write with bit 1 = 1 enters `S_PDOWN` and sets `osc_en` = 0. Bit 1 wins when both bits are set. Only a qualified reset leaves `S_PDOWN`.
- R7: A qualified reset clears `pcon_q` to 00. `sys_rst` stays 1 while `rst_in` stays high. `sys_rst` is 0 after the first edge that samples `rst_in` low, and the block is then back in `S_RUN`. A reset wins over an interrupt or a register write that arrives in the same cycle.
- R8: Divide-by-two: `per_clk_en` is 1 on every second `osc_tick`. Over any 8 consecutive ticks it pulses 4 times. `cpu_clk_en` does the same in `S_RUN` and `S_RESET`.
- R9: Register writes are ignored outside `S_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| osc_tick | input | 1 | One strobe per oscillator period; absent while the oscillator is stopped |
| rst_in | input | 1 | External reset pin level |
| pcon_we | input | 1 | Power-control register write strobe |
| pcon_wdata | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| irq | input | 1 | Any enabled interrupt pending |
| pcon_q | output | 2 | Power-control register contents |
| cpu_clk_en | output | 1 | CPU clock enable pulse |
| per_clk_en | output | 1 | Peripheral clock enable pulse |
| osc_en | output | 1 | Oscillator enable |
| sys_rst | output | 1 | Synchronous system reset |

## Verification
Reset recognition can land in the same cycle as an idle wake-up interrupt. It can also land in the same cycle as a software write to the power-control register. The bench holds `rst_in` high for 23 counted ticks and raises `irq`, or a write, just before the 24th. It then expects `sys_rst` = 1 with `pcon_q` = 00 after that edge: the reset must win. Reset qualification is also checked at the one-tick boundary (23 ticks give no reset, 24 ticks do) in both the oscillator-timed and the reference-timed case.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        S_RUN   = 2'd0,
        S_IDLE  = 2'd1,
        S_PDOWN = 2'd2,
        S_RESET = 2'd3
    } pm_state_e;

    localparam int PCON_W  = 2;
    localparam int IDLE_B  = 0;
    localparam int PDOWN_B = 1;
endpackage

// File: rtl/pmc_div2.sv
module pmc_div2 (
    input  logic clk,
    input  logic arst_n,
    input  logic osc_tick,
    output logic phase_en
);
    logic div_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)       div_q <= 1'b0;
        else if (osc_tick) div_q <= ~div_q;
    end

    assign phase_en = osc_tick & div_q;

    // R8: the halved clock never pulses on two successive ticks
    a_r8_alternate: assert property (@(posedge clk) disable iff (!arst_n)
        phase_en |=> !phase_en || !$past(osc_tick));
endmodule

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
    parameter int MC_PERIODS = 12,
    parameter int MC_COUNT   = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_in,
    input  logic tick,
    output logic hit
);
    localparam int QUAL  = MC_PERIODS * MC_COUNT;
    localparam int CNT_W = $clog2(QUAL + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                               cnt <= '0;
        else if (!rst_in)                          cnt <= '0;
        else if (tick && cnt < CNT_W'(QUAL))       cnt <= cnt + 1'b1;
    end

    assign hit = rst_in && tick && (cnt == CNT_W'(QUAL - 1));

    // R2: a low sample always restarts the qualification window
    a_r2_restart: assert property (@(posedge clk) disable iff (!arst_n)
        !rst_in |=> cnt == '0);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              arst_n,
    input  logic              rst_hit,
    input  logic              rst_in,
    input  logic              pcon_we,
    input  logic [PCON_W-1:0] pcon_wdata,
    input  logic              irq,
    output pm_state_e         state,
    output logic [PCON_W-1:0] pcon_q
);
    pm_state_e         state_nx;
    logic [PCON_W-1:0] pcon_nx;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state  <= S_RUN;
            pcon_q <= '0;
        end else begin
            state  <= state_nx;
            pcon_q <= pcon_nx;
        end
    end

    always_comb begin
        state_nx = state;
        pcon_nx  = pcon_q;
        unique case (state)
            S_RUN: begin
                if (pcon_we) begin
                    pcon_nx = pcon_wdata;
                    if (pcon_wdata[PDOWN_B])     state_nx = S_PDOWN;
                    else if (pcon_wdata[IDLE_B]) state_nx = S_IDLE;
                end
            end
            S_IDLE: begin
                if (irq) begin
                    state_nx        = S_RUN;
                    pcon_nx[IDLE_B] = 1'b0;
                end
            end
            S_PDOWN: begin
                state_nx = S_PDOWN;
            end
            S_RESET: begin
                if (!rst_in) state_nx = S_RUN;
            end
        endcase
        if (rst_hit) begin
            state_nx = S_RESET;
            pcon_nx  = '0;
        end
    end

    // R6: power-down is left only through a qualified reset
    a_r6_pd_sticky: assert property (@(posedge clk) disable iff (!arst_n)
        (state == S_PDOWN && !rst_hit) |=> state == S_PDOWN);
    // R5: an interrupt wakes idle unless a reset arrives together with it
    a_r5_wake: assert property (@(posedge clk) disable iff (!arst_n)
        (state == S_IDLE && irq && !rst_hit) |=> (state == S_RUN && !pcon_q[IDLE_B]));
    // R7: while held in reset the control bits stay clear
    a_r7_clear: assert property (@(posedge clk) disable iff (!arst_n)
        (state == S_RESET) |-> pcon_q == '0);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int MC_PERIODS = 12,
    parameter int MC_COUNT   = 2
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              osc_tick,
    input  logic              rst_in,
    input  logic              pcon_we,
    input  logic [PCON_W-1:0] pcon_wdata,
    input  logic              irq,
    output logic [PCON_W-1:0] pcon_q,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_en,
    output logic              sys_rst
);
    pm_state_e state;
    logic      phase_en;
    logic      qual_tick;
    logic      rst_hit;

    pmc_div2 u_div (
        .clk      (clk),
        .arst_n   (arst_n),
        .osc_tick (osc_tick),
        .phase_en (phase_en)
    );

    assign qual_tick = (state == S_PDOWN) ? 1'b1 : osc_tick;

    pmc_rst_qual #(
        .MC_PERIODS (MC_PERIODS),
        .MC_COUNT   (MC_COUNT)
    ) u_qual (
        .clk    (clk),
        .arst_n (arst_n),
        .rst_in (rst_in),
        .tick   (qual_tick),
        .hit    (rst_hit)
    );

    pmc_fsm u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .rst_hit    (rst_hit),
        .rst_in     (rst_in),
        .pcon_we    (pcon_we),
        .pcon_wdata (pcon_wdata),
        .irq        (irq),
        .state      (state),
        .pcon_q     (pcon_q)
    );

    always_comb begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        osc_en     = 1'b1;
        sys_rst    = 1'b0;
        unique case (state)
            S_RUN:   begin cpu_clk_en = phase_en; per_clk_en = phase_en; end
            S_IDLE:  begin per_clk_en = phase_en; end
            S_PDOWN: begin osc_en = 1'b0; end
            S_RESET: begin cpu_clk_en = phase_en; per_clk_en = phase_en; sys_rst = 1'b1; end
        endcase
    end

    // R2: system reset only begins after the pin was already high
    a_r2_no_early: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sys_rst) |-> $past(rst_in));
    // R7: releasing the pin releases the system reset one edge later
    a_r7_release: assert property (@(posedge clk) disable iff (!arst_n)
        (sys_rst && !rst_in) |=> !sys_rst);
    // R4: the CPU is never clocked while the oscillator is off
    a_r4_no_cpu_pd: assert property (@(posedge clk) disable iff (!arst_n)
        !osc_en |-> !cpu_clk_en);
endmodule

// File: tb/pmc_top_tb.sv
module pmc_top_tb;
    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       rst_in = 1'b0;
    logic       pcon_we = 1'b0;
    logic [1:0] pcon_wdata = 2'b00;
    logic       irq = 1'b0;
    logic [1:0] pcon_q;
    logic       cpu_clk_en, per_clk_en, osc_en, sys_rst;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pmc_top u_dut (
        .clk(clk), .arst_n(arst_n), .osc_tick(osc_tick), .rst_in(rst_in),
        .pcon_we(pcon_we), .pcon_wdata(pcon_wdata), .irq(irq),
        .pcon_q(pcon_q), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .sys_rst(sys_rst)
    );

    // {we, wdata[1:0], irq, exp_osc_en, exp_pcon[1:0]}
    localparam logic [6:0] VEC [6] = '{
        7'b1_01_0_1_01,   // R4 enter idle
        7'b0_00_0_1_01,   // R4 stays idle
        7'b0_00_1_1_00,   // R5 irq wakes
        7'b0_00_1_1_00,   // R5 irq in run: no effect
        7'b1_11_0_0_11,   // R6 both bits: power-down wins
        7'b0_00_1_0_11    // R6 irq ignored in power-down
    };

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic count_pulses(int n, output int cpu, output int per);
        cpu = 0; per = 0;
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1;
            #1;
            cpu += int'(cpu_clk_en);
            per += int'(per_clk_en);
            step();
        end
    endtask

    task automatic hold_rst(int n);
        rst_in = 1'b1;
        repeat (n) step();
    endtask

    initial begin
        int c, p;
        #20 arst_n = 1'b1;
        step();
        chk("R1 pcon", pcon_q, 0);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 sys_rst", sys_rst, 0);

        count_pulses(8, c, p);
        chk("R8 cpu pulses", c, 4);
        chk("R8 per pulses", p, 4);
        osc_tick = 1'b0;

        for (int i = 0; i < 6; i++) begin
            {pcon_we, pcon_wdata, irq} = VEC[i][6:3];
            step();
            chk($sformatf("vec%0d osc_en", i), osc_en, int'(VEC[i][2]));
            chk($sformatf("vec%0d pcon", i), pcon_q, int'(VEC[i][1:0]));
        end
        pcon_we = 1'b0; irq = 1'b0;

        // R3: power-down, oscillator stopped, reference clock counts
        hold_rst(23);
        chk("R3 23 cycles", sys_rst, 0);
        step();
        chk("R3 24 cycles", sys_rst, 1);
        chk("R7 pcon cleared", pcon_q, 0);
        chk("R7 osc back", osc_en, 1);
        pcon_we = 1'b1; pcon_wdata = 2'b01;
        step();
        pcon_we = 1'b0;
        chk("R9 write ignored", pcon_q, 0);
        chk("R7 held", sys_rst, 1);
        rst_in = 1'b0;
        step();
        chk("R7 release", sys_rst, 0);

        // R2: running, qualification counts oscillator ticks only
        hold_rst(40);
        chk("R2 no ticks", sys_rst, 0);
        osc_tick = 1'b1;
        hold_rst(23);
        rst_in = 1'b0;
        step();
        chk("R2 short pulse", sys_rst, 0);
        hold_rst(23);
        chk("R2 restart 23", sys_rst, 0);
        step();
        chk("R2 24 ticks", sys_rst, 1);
        rst_in = 1'b0;
        step();

        // R4: idle gates CPU only
        pcon_we = 1'b1; pcon_wdata = 2'b01;
        step();
        pcon_we = 1'b0;
        count_pulses(8, c, p);
        chk("R4 cpu gated", c, 0);
        chk("R4 per running", p, 4);

        // R7: reset and irq in the same cycle
        hold_rst(23);
        irq = 1'b1;
        step();
        irq = 1'b0;
        chk("R7 reset beats irq", sys_rst, 1);
        chk("R7 pcon after irq race", pcon_q, 0);
        rst_in = 1'b0;
        step();

        // R6: bit 1 alone gives power-down
        pcon_we = 1'b1; pcon_wdata = 2'b10;
        step();
        pcon_we = 1'b0;
        chk("R6 pd only", osc_en, 0);
        osc_tick = 1'b0;
        hold_rst(24);
        rst_in = 1'b0;
        step();
        osc_tick = 1'b1;

        // R7: reset and write in the same cycle
        hold_rst(23);
        pcon_we = 1'b1; pcon_wdata = 2'b10;
        step();
        pcon_we = 1'b0;
        chk("R7 reset beats write", sys_rst, 1);
        chk("R7 pcon after write race", pcon_q, 0);
        chk("R7 osc after write race", osc_en, 1);
        rst_in = 1'b0;
        step();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule